// File: doc/BRIEF.md
# Issue Window Wakeup Logic

This block holds the source-operand readiness state for the entries of an out-of-order issue window. Each entry records a left and a right source tag and a ready flag for each. Every cycle up to IW result tags arrive on a broadcast bus. Every occupied entry compares each valid broadcast tag with both of its source tags in parallel, so it has two comparators per lane. A match sets the ready flag of that operand. An entry asserts its request bit once both flags are set. A downstream selector reads the request vector and grants entries.

New instructions come in on a valid/ready insert port. The port accepts on a rising edge when `ins_valid` and `ins_ready` are both high. `ins_ready` depends only on window occupancy, never on `ins_valid`, and is low exactly when every entry is occupied. While `ins_valid` is low, or while `ins_ready` is low, nothing is written. While `ins_ready` is high, `ins_slot` names the lowest-numbered free entry, which is where the instruction will be written. An operand with no pending producer is inserted with its ready bit already set. The selector returns granted entries on the `clr` vector, and each returned entry is emptied at the next edge.

Top module: `wk_issue_wakeup`

## Requirements
- R1: After reset the window is empty: `req` is all zeros, `ins_ready` is 1 and `ins_slot` is 0.
- R2: A broadcast lane whose valid bit is 1 and whose tag equals an occupied entry's left source tag sets that entry's left-ready flag at the next edge.
- R3: A valid broadcast lane whose tag equals an occupied entry's right source tag sets that entry's right-ready flag at the next edge.
- R4: `req[i]` is 1 exactly when entry i is occupied and both of its ready flags are set. An entry with only one operand ready does not request.
- R5: A broadcast lane whose valid bit is 0 wakes nothing, even when its tag matches.
- R6: An accepted insert writes the lowest-numbered free entry, which `ins_slot` reports in the accepting cycle. The inserted ready bits are stored as given, so an insert with both bits set requests one edge later.
- R7: A valid broadcast in the same cycle as an insert wakes the incoming operand whose tag matches.
- R8: `clr[i]` empties entry i at the next edge, so its request drops. The clear takes priority over a wakeup of that entry in the same cycle, and the entry becomes free for later inserts.
- R9: Any lane can wake an operand. Two lanes in one cycle can wake the left and right operands of one entry together.
- R10: When all entries are occupied, `ins_ready` is 0 and an insert offered with `ins_valid` high changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Insert request |
| ins_ready | output | 1 | A free entry exists |
| ins_tag_l | input | TAG_W | Left source tag of the incoming instruction |
| ins_rdy_l | input | 1 | Left operand already available |
| ins_tag_r | input | TAG_W | Right source tag of the incoming instruction |
| ins_rdy_r | input | 1 | Right operand already available |
| ins_slot | output | $clog2(ENTRIES) | Entry that an accepted insert writes |
| bc_valid | input | IW | Valid bit per broadcast lane |
| bc_tag | input | IW*TAG_W | Broadcast tags; lane k occupies bits [k*TAG_W +: TAG_W] |
| clr | input | ENTRIES | Per-entry empty command from issue |
| req | output | ENTRIES | Per-entry ready request |

## Verification
`ins_ready` and `ins_slot` are combinational from occupancy, so they are due in the same cycle as the stimulus. `req` has exactly one register on its path, so it is due one rising edge after any insert, broadcast or clear. The bench drives every input on the falling edge. It checks the insert outputs just before the next rising edge and checks `req` on the falling edge that follows that rising edge. With this sampling, each `req` check covers exactly one edge of state change.

// File: rtl/wk_pkg.sv
package wk_pkg;
  localparam int unsigned WK_ENTRIES_DEF = 8;
  localparam int unsigned WK_IW_DEF      = 2;
  localparam int unsigned WK_TAG_W_DEF   = 6;

  typedef enum logic {OPND_LEFT = 1'b0, OPND_RIGHT = 1'b1} opnd_side_e;
endpackage

// File: rtl/wk_tag_match.sv
module wk_tag_match #(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic [TAG_W-1:0]    tag,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  output logic                hit
);
  logic [IW-1:0] lane_hit;

  for (genvar k = 0; k < IW; k++) begin : g_lane
    assign lane_hit[k] = bc_valid[k] && (bc_tag[k*TAG_W +: TAG_W] == tag);
  end

  assign hit = |lane_hit;
endmodule

// File: rtl/wk_alloc.sv
module wk_alloc #(
  parameter int unsigned ENTRIES = 8,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] busy,
  output logic               any_free,
  output logic [IDX_W-1:0]   free_idx
);
  always_comb begin
    any_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!busy[i]) begin
        any_free = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/wk_slot.sv
module wk_slot
  import wk_pkg::*;
#(
  parameter int unsigned TAG_W = 6,
  parameter int unsigned IW    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [TAG_W-1:0]    ld_tag_l,
  input  logic                ld_rdy_l,
  input  logic [TAG_W-1:0]    ld_tag_r,
  input  logic                ld_rdy_r,
  input  logic                clr,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  output logic                busy,
  output logic                req
);
  logic             valid_q;
  logic [TAG_W-1:0] tag_q [2];
  logic [1:0]       rdy_q;
  logic [1:0]       hit;

  for (genvar s = 0; s < 2; s++) begin : g_side
    wk_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match (
      .tag      (tag_q[s]),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .hit      (hit[s])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q  <= 1'b0;
      rdy_q    <= '0;
      tag_q[0] <= '0;
      tag_q[1] <= '0;
    end else if (clr) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
    end else if (load) begin
      valid_q           <= 1'b1;
      tag_q[OPND_LEFT]  <= ld_tag_l;
      tag_q[OPND_RIGHT] <= ld_tag_r;
      rdy_q             <= {ld_rdy_r, ld_rdy_l};
    end else if (valid_q) begin
      rdy_q <= rdy_q | hit;
    end
  end

  assign busy = valid_q;
  assign req  = valid_q & rdy_q[OPND_LEFT] & rdy_q[OPND_RIGHT];

  a_r8_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !req);
  a_r2_left_wake: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !clr && hit[0] |=> rdy_q[0]);
  a_r3_right_wake: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q && !clr && hit[1] |=> rdy_q[1]);
endmodule

// File: rtl/wk_issue_wakeup.sv
module wk_issue_wakeup
  import wk_pkg::*;
#(
  parameter int unsigned ENTRIES = WK_ENTRIES_DEF,
  parameter int unsigned IW      = WK_IW_DEF,
  parameter int unsigned TAG_W   = WK_TAG_W_DEF,
  localparam int unsigned IDX_W  = $clog2(ENTRIES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ins_valid,
  output logic                ins_ready,
  input  logic [TAG_W-1:0]    ins_tag_l,
  input  logic                ins_rdy_l,
  input  logic [TAG_W-1:0]    ins_tag_r,
  input  logic                ins_rdy_r,
  output logic [IDX_W-1:0]    ins_slot,
  input  logic [IW-1:0]       bc_valid,
  input  logic [IW*TAG_W-1:0] bc_tag,
  input  logic [ENTRIES-1:0]  clr,
  output logic [ENTRIES-1:0]  req
);
  logic [ENTRIES-1:0] busy;
  logic [ENTRIES-1:0] load;
  logic               in_hit_l, in_hit_r;
  logic               accept;

  wk_alloc #(.ENTRIES(ENTRIES)) u_alloc (
    .busy     (busy),
    .any_free (ins_ready),
    .free_idx (ins_slot)
  );

  wk_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_in_l (
    .tag (ins_tag_l), .bc_valid (bc_valid), .bc_tag (bc_tag), .hit (in_hit_l)
  );
  wk_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_in_r (
    .tag (ins_tag_r), .bc_valid (bc_valid), .bc_tag (bc_tag), .hit (in_hit_r)
  );

  assign accept = ins_valid && ins_ready;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign load[i] = accept && (ins_slot == IDX_W'(i));
    wk_slot #(.TAG_W(TAG_W), .IW(IW)) u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load[i]),
      .ld_tag_l (ins_tag_l),
      .ld_rdy_l (ins_rdy_l | in_hit_l),
      .ld_tag_r (ins_tag_r),
      .ld_rdy_r (ins_rdy_r | in_hit_r),
      .clr      (clr[i]),
      .bc_valid (bc_valid),
      .bc_tag   (bc_tag),
      .busy     (busy[i]),
      .req      (req[i])
    );
  end

  a_r6_slot_free: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !busy[ins_slot]);
  a_r6_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(load));
  a_r10_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (&busy) |-> !ins_ready);
endmodule

// File: tb/tb_wk_issue_wakeup.sv
module tb_wk_issue_wakeup;
  localparam int PERIOD = 10;
  localparam int N = 8, IW = 2, TW = 6, IDXW = 3;

  typedef struct packed {
    bit          iv;
    bit [5:0]    tl;
    bit          rl;
    bit [5:0]    tr;
    bit          rr;
    bit [1:0]    bv;
    bit [11:0]   bt;
    bit [7:0]    cl;
    bit [2:0]    eslot;
    bit [7:0]    ereq;
    bit [3:0]    rq;
  } vec_t;

  localparam int NV = 13;
  // rq column names the requirement each step exercises
  localparam vec_t VEC [NV] = '{
    '{1'b1, 6'd5,  1'b0, 6'd6,  1'b0, 2'b00, 12'd0,             8'h00, 3'd0, 8'h00, 4'd6}, // R6
    '{1'b1, 6'd7,  1'b1, 6'd0,  1'b1, 2'b00, 12'd0,             8'h00, 3'd1, 8'h02, 4'd6}, // R6
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b01, {6'd0,  6'd5},     8'h00, 3'd0, 8'h02, 4'd2}, // R2, R4
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b10, {6'd6,  6'd0},     8'h00, 3'd0, 8'h03, 4'd3}, // R3
    '{1'b1, 6'd9,  1'b0, 6'd10, 1'b0, 2'b00, 12'd0,             8'h00, 3'd2, 8'h03, 4'd6},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b00, {6'd10, 6'd9},     8'h00, 3'd0, 8'h03, 4'd5}, // R5
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b11, {6'd9,  6'd10},    8'h00, 3'd0, 8'h07, 4'd9}, // R9
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b00, 12'd0,             8'h01, 3'd0, 8'h06, 4'd8}, // R8
    '{1'b1, 6'd20, 1'b0, 6'd21, 1'b1, 2'b10, {6'd20, 6'd0},     8'h00, 3'd0, 8'h07, 4'd7}, // R7
    '{1'b1, 6'd30, 1'b0, 6'd31, 1'b0, 2'b00, 12'd0,             8'h06, 3'd3, 8'h01, 4'd8},
    '{1'b1, 6'd33, 1'b1, 6'd34, 1'b0, 2'b00, 12'd0,             8'h00, 3'd1, 8'h01, 4'd6},
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b01, {6'd0,  6'd34},    8'h02, 3'd0, 8'h01, 4'd8}, // R8 priority
    '{1'b0, 6'd0,  1'b0, 6'd0,  1'b0, 2'b11, {6'd31, 6'd30},    8'h00, 3'd0, 8'h09, 4'd9}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid = 1'b0, ins_ready;
  logic [TW-1:0] ins_tag_l = '0, ins_tag_r = '0;
  logic ins_rdy_l = 1'b0, ins_rdy_r = 1'b0;
  logic [IDXW-1:0] ins_slot;
  logic [IW-1:0] bc_valid = '0;
  logic [IW*TW-1:0] bc_tag = '0;
  logic [N-1:0] clr = '0, req;

  int n_chk = 0, n_fail = 0;

  always #(PERIOD/2) clk = ~clk;

  wk_issue_wakeup dut (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_tag_l(ins_tag_l), .ins_rdy_l(ins_rdy_l), .ins_tag_r(ins_tag_r),
    .ins_rdy_r(ins_rdy_r), .ins_slot(ins_slot), .bc_valid(bc_valid),
    .bc_tag(bc_tag), .clr(clr), .req(req)
  );

  task automatic check(input string rq, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", rq, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 1'b0; ins_rdy_l = 1'b0; ins_rdy_r = 1'b0;
    ins_tag_l = '0; ins_tag_r = '0; bc_valid = '0; bc_tag = '0; clr = '0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(PERIOD * 20000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1 req", int'(req), 0);
    check("R1 ins_ready", int'(ins_ready), 1);
    check("R1 ins_slot", int'(ins_slot), 0);

    for (int v = 0; v < NV; v++) begin
      ins_valid = VEC[v].iv; ins_tag_l = VEC[v].tl; ins_rdy_l = VEC[v].rl;
      ins_tag_r = VEC[v].tr; ins_rdy_r = VEC[v].rr;
      bc_valid = VEC[v].bv; bc_tag = VEC[v].bt; clr = VEC[v].cl;
      #1;
      if (VEC[v].iv) check($sformatf("R%0d slot v%0d", VEC[v].rq, v), int'(ins_slot), int'(VEC[v].eslot));
      step();
      check($sformatf("R%0d req v%0d", VEC[v].rq, v), int'(req), int'(VEC[v].ereq));
      idle();
    end

    // R1: reset mid-run empties the window
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    check("R1 req after reset", int'(req), 0);
    check("R1 ready after reset", int'(ins_ready), 1);

    // R6: fill in index order with ready operands
    for (int i = 0; i < N; i++) begin
      ins_valid = 1'b1; ins_tag_l = TW'(40 + i); ins_tag_r = TW'(50 + i);
      ins_rdy_l = 1'b1; ins_rdy_r = 1'b1;
      #1;
      check("R6 fill slot", int'(ins_slot), i);
      step();
    end
    idle();
    check("R6 all request", int'(req), 8'hFF);
    check("R10 full not ready", int'(ins_ready), 0);

    // R10: offered insert while full is not taken
    ins_valid = 1'b1; ins_tag_l = 6'd60; ins_tag_r = 6'd61;
    #1;
    check("R10 ready low while offered", int'(ins_ready), 0);
    step();
    idle();
    check("R10 req unchanged", int'(req), 8'hFF);

    // R8: clear frees a slot that becomes the next target
    clr = 8'h20;
    step();
    idle();
    check("R8 req after clear", int'(req), 8'hDF);
    check("R8 ready after clear", int'(ins_ready), 1);
    check("R8 freed slot", int'(ins_slot), 5);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule